// File: doc/BRIEF.md
# 64-bit Interval Timer

This block is a memory-mapped interval timer with a 64-bit up-counter, a 64-bit terminal count and a level interrupt. Software reaches it through a plain 32-bit register port (byte address, write strobe, write data, read strobe, read data). It sets a terminal count, picks continuous or single-event operation, a 4-bit divider and one of two counting sources, then starts the timer. Each time the count reaches the terminal count a period event is recorded in a pending flag. That flag drives the interrupt when it is enabled, and a read of the status register clears it.

Both counting sources live in the single clock domain. The primary source is every clock cycle. The alternate source is an enable pulse on `altTick`, and it may pulse at most once every three clock cycles. The 64-bit count is read as two 32-bit halves. Reading the low half captures the high half at the same edge, so the pair is always a coherent sample, however long the gap before the high half is read.

Top module: `interval_timer64`

## Requirements
- R1: After reset `irqOut` is 0, the count reads 0, the status register reads 0, the mode register reads 0, and the timer is stopped.
- R2: Byte addresses: control 0x00, mode 0x04, terminal-count low 0x08, terminal-count high 0x0C, interrupt enable 0x10, status 0x1C, count low 0x20, count high 0x24. Mode bit 0 is continuous, bit 3 is alternate source, and bits 11:8 hold the divider p. The mode register reads back only those bits. Interrupt enable is bit 0 and reads back only that bit. The control register always reads 0.
- R3: A write to 0x0C only stages the high word. A write to 0x08 commits {staged high, written low} as the terminal count P. A staged high word has no effect on a running timer until 0x08 is written.
- R4: Start (control bit 0) zeroes the count and the divider. The count then rises by one on each divided tick. The event fires on the tick where count equals P, so the first event falls (P+1)·(p+1) source ticks after the start edge.
- R5: Every divider setting p = 0..15 divides the selected source by p+1.
- R6: In continuous mode (mode bit 0 = 1) the count returns to 0 at each event, and events repeat every (P+1)·(p+1) source ticks.
- R7: In single-event mode (mode bit 0 = 0) exactly one event fires. The timer then stops with the count held at P.
- R8: With mode bit 3 set, only `altTick` pulses advance the divider. The count does not move while `altTick` stays low.
- R9: An event sets the pending flag (status bit 0) whether or not the interrupt is enabled. `irqOut` equals pending AND enable bit 0. A status read returns the flag and clears it, but an event in the same cycle keeps it set.
- R10: Reading count low captures count[63:32]. Later reads of count high return that captured word, even after the live count has carried into the high half.
- R11: Writing control bit 8 stops the timer and clears the count, the divider, the pending flag and the captured high word. Mode, terminal count and enable keep their values. A start bit in the same write is ignored.
- R12: Writing start while running restarts the count from 0 with the current terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the primary counting source |
| rstN | input | 1 | Asynchronous active-low reset |
| altTick | input | 1 | Alternate counting source enable pulse |
| busAddr | input | 6 | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe; read side effects occur at the clock edge |
| busRdata | output | 32 | Read data, valid in the cycle of busRe |
| irqOut | output | 1 | Level period interrupt |

## Verification
The assertions check on every cycle that the control register reads zero, that a status read with no event in the same cycle drops the interrupt, and that a software reset zeroes the count and the interrupt. They also check that a continuous event returns the count to zero and that a single-event run freezes the count after its event. The exact event timing over all divider settings, the staged high word of the terminal count, alternate-source counting and the coherent count read across a low-word carry depend on multi-step scenarios, so only the bench shows them.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  parameter int unsigned BUS_W  = 32;
  parameter int unsigned CNT_W  = 2 * BUS_W;
  parameter int unsigned PRES_W = 4;
  parameter int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] ADR_MODE  = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] ADR_PERLO = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] ADR_PERHI = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] ADR_IEN   = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] ADR_STAT  = ADDR_W'(6'h1C);
  localparam logic [ADDR_W-1:0] ADR_CNTLO = ADDR_W'(6'h20);
  localparam logic [ADDR_W-1:0] ADR_CNTHI = ADDR_W'(6'h24);

  localparam int unsigned CTL_START_B   = 0;
  localparam int unsigned CTL_SWRST_B   = 8;
  localparam int unsigned MODE_CONT_B   = 0;
  localparam int unsigned MODE_ALT_B    = 3;
  localparam int unsigned MODE_PRES_LSB = 8;

  // Strobes and settings handed from the register side to the counting side.
  typedef struct packed {
    logic              start;
    logic              swrst;
    logic              cont;
    logic              altSel;
    logic [PRES_W-1:0] presc;
    logic [CNT_W-1:0]  period;
  } ivtCtl_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              busRe,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              perEvt,
  output ivtCtl_t           ctl,
  output logic              irqOut
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  logic              modeCont;
  logic              modeAlt;
  logic [PRES_W-1:0] modePres;
  logic [HI_W-1:0]   perStage;
  logic [CNT_W-1:0]  period;
  logic              ierEn;
  logic              pending;
  logic [HI_W-1:0]   snapHi;
  logic              ctrlWr;
  logic              statRd;
  logic              loRd;

  assign ctrlWr = busWe && (busAddr == ADR_CTRL);
  assign statRd = busRe && (busAddr == ADR_STAT);
  assign loRd   = busRe && (busAddr == ADR_CNTLO);

  // Reset takes precedence over start within one control write.
  assign ctl.swrst  = ctrlWr && busWdata[CTL_SWRST_B];
  assign ctl.start  = ctrlWr && busWdata[CTL_START_B] && !busWdata[CTL_SWRST_B];
  assign ctl.cont   = modeCont;
  assign ctl.altSel = modeAlt;
  assign ctl.presc  = modePres;
  assign ctl.period = period;

  // Configuration registers; software reset leaves them untouched.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCont <= 1'b0;
      modeAlt  <= 1'b0;
      modePres <= '0;
      perStage <= '0;
      period   <= '0;
      ierEn    <= 1'b0;
    end else if (busWe) begin
      case (busAddr)
        ADR_MODE: begin
          modeCont <= busWdata[MODE_CONT_B];
          modeAlt  <= busWdata[MODE_ALT_B];
          modePres <= busWdata[MODE_PRES_LSB +: PRES_W];
        end
        ADR_PERHI: perStage <= busWdata[HI_W-1:0];
        ADR_PERLO: period   <= {perStage, busWdata};
        ADR_IEN:   ierEn    <= busWdata[0];
        default: ;
      endcase
    end
  end

  // Pending flag: reset, then a new event, then a clearing read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (ctl.swrst) begin
      pending <= 1'b0;
    end else if (perEvt) begin
      pending <= 1'b1;
    end else if (statRd) begin
      pending <= 1'b0;
    end
  end

  // High half captured by the low-half read.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapHi <= '0;
    end else if (ctl.swrst) begin
      snapHi <= '0;
    end else if (loRd) begin
      snapHi <= count[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      case (busAddr)
        ADR_MODE: begin
          busRdata[MODE_CONT_B]                 = modeCont;
          busRdata[MODE_ALT_B]                  = modeAlt;
          busRdata[MODE_PRES_LSB +: PRES_W]     = modePres;
        end
        ADR_PERLO: busRdata = period[BUS_W-1:0];
        ADR_PERHI: busRdata = perStage;
        ADR_IEN:   busRdata[0] = ierEn;
        ADR_STAT:  busRdata[0] = pending;
        ADR_CNTLO: busRdata = count[BUS_W-1:0];
        ADR_CNTHI: busRdata = snapHi;
        default:   busRdata = '0;
      endcase
    end
  end

  assign irqOut = pending && ierEn;
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ivtCtl_t          ctl,
  input  logic             altTick,
  output logic [CNT_W-1:0] count,
  output logic             perEvt
);
  logic [PRES_W-1:0] presCnt;
  logic              running;
  logic              selTick;
  logic              divTick;
  logic              atTerm;

  assign selTick = ctl.altSel ? altTick : 1'b1;
  assign divTick = running && selTick && (presCnt >= ctl.presc);
  assign atTerm  = (count == ctl.period);
  assign perEvt  = divTick && atTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      presCnt <= '0;
      count   <= '0;
    end else if (ctl.swrst) begin
      running <= 1'b0;
      presCnt <= '0;
      count   <= '0;
    end else if (ctl.start) begin
      running <= 1'b1;
      presCnt <= '0;
      count   <= '0;
    end else if (running && selTick) begin
      if (divTick) begin
        presCnt <= '0;
        if (atTerm) begin
          if (ctl.cont) begin
            count <= '0;
          end else begin
            running <= 1'b0;
          end
        end else begin
          count <= count + 1'b1;
        end
      end else begin
        presCnt <= presCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/interval_timer64.sv
module interval_timer64
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              altTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic              busRe,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqOut
);
  ivtCtl_t          ctl;
  logic [CNT_W-1:0] count;
  logic             perEvt;

  ivt_ctrl ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRe    (busRe),
    .busRdata (busRdata),
    .count    (count),
    .perEvt   (perEvt),
    .ctl      (ctl),
    .irqOut   (irqOut)
  );

  ivt_datapath dpI (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .altTick (altTick),
    .count   (count),
    .perEvt  (perEvt)
  );
endmodule

// File: rtl/interval_timer64_chk.sv
module interval_timer64_chk
  import ivt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [BUS_W-1:0]  busWdata,
  input logic              busRe,
  input logic [BUS_W-1:0]  busRdata,
  input logic              irqOut,
  input logic              perEvt,
  input logic [CNT_W-1:0]  count,
  input logic              modeCont
);
  logic ctrlWr;
  assign ctrlWr = busWe && (busAddr == ADR_CTRL);

  p_ctrl_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADR_CTRL) |-> (busRdata == '0));

  p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (perEvt && modeCont && !ctrlWr) |=> (count == '0));

  p_single_event_halts_r7: assert property (@(posedge clk) disable iff (!rstN)
    (perEvt && !modeCont && !ctrlWr) |=> (!perEvt && $stable(count)));

  p_stat_read_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADR_STAT && !perEvt) |=> !irqOut);

  p_swrst_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWdata[CTL_SWRST_B]) |=> (count == '0 && !irqOut));
endmodule

bind interval_timer64 interval_timer64_chk chkI (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRe    (busRe),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .perEvt   (perEvt),
  .count    (count),
  .modeCont (ctl.cont)
);

// File: tb/interval_timer64_tb_top.sv
`timescale 1ns/1ps
module interval_timer64_tb_top;
  import ivt_pkg::*;

  localparam int WD_CYCLES  = 150000;
  localparam int WAIT_LIMIT = 2000;
  localparam int NVEC       = 20;
  // Each entry: {divider p[3:0], terminal count P[7:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    12'h000, 12'h101, 12'h202, 12'h303, 12'h404, 12'h505, 12'h606, 12'h707,
    12'h802, 12'h902, 12'hA02, 12'hB02, 12'hC02, 12'hD02, 12'hE02, 12'hF02,
    12'h020, 12'hF00, 12'h30A, 12'h701
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              altTick = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [BUS_W-1:0]  busWdata = '0;
  logic              busRe = 1'b0;
  logic [BUS_W-1:0]  busRdata;
  logic              irqOut;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  int startCyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_timer64 dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .altTick  (altTick),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .busRe    (busRe),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  task automatic chkEq(input string req, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [BUS_W-1:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  function automatic logic [BUS_W-1:0] modeWord(input int p, input bit alt, input bit cont);
    return BUS_W'((p << MODE_PRES_LSB) | (int'(alt) << MODE_ALT_B) | int'(cont));
  endfunction

  task automatic arm(input logic [BUS_W-1:0] m, input logic [BUS_W-1:0] hi,
                     input logic [BUS_W-1:0] lo, input logic ien);
    wr(ADR_CTRL, 32'h100);
    wr(ADR_MODE, m);
    wr(ADR_PERHI, hi);
    wr(ADR_PERLO, lo);
    wr(ADR_IEN, {31'b0, ien});
    wr(ADR_CTRL, 32'h1);
    startCyc = cyc;
  endtask

  task automatic waitIrq(output int delta);
    int k = 0;
    while (!irqOut && k < WAIT_LIMIT) begin
      @(negedge clk);
      k++;
    end
    delta = cyc - startCyc;
  endtask

  task automatic pulseAlt();
    @(negedge clk); altTick = 1'b1;
    @(negedge clk); altTick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [BUS_W-1:0] d;
    int dl;

    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: idle state after reset
    chkEq("R1 irq after reset", irqOut, 0);
    rd(ADR_CNTLO, d); chkEq("R1 count low", d, 0);
    rd(ADR_CNTHI, d); chkEq("R1 count high", d, 0);
    rd(ADR_STAT, d);  chkEq("R1 status", d, 0);
    rd(ADR_MODE, d);  chkEq("R1 mode", d, 0);

    // R2: field readback and control reads zero
    wr(ADR_MODE, 32'hFFFF_FFFF);
    rd(ADR_MODE, d); chkEq("R2 mode readback", d, 32'h0F09);
    wr(ADR_CTRL, 32'h0000_0000);
    rd(ADR_CTRL, d); chkEq("R2 control reads zero", d, 0);
    wr(ADR_IEN, 32'hFFFF_FFFF);
    rd(ADR_IEN, d); chkEq("R2 enable readback", d, 1);

    // R3: high word staged until the low-word write
    wr(ADR_CTRL, 32'h100);
    wr(ADR_MODE, modeWord(0, 1'b0, 1'b0));
    wr(ADR_PERHI, 32'h0);
    wr(ADR_PERLO, 32'h3);
    wr(ADR_PERHI, 32'h5);
    rd(ADR_PERHI, d); chkEq("R3 staged high", d, 5);
    rd(ADR_PERLO, d); chkEq("R3 committed low", d, 3);
    wr(ADR_IEN, 32'h1);
    wr(ADR_CTRL, 32'h1);
    startCyc = cyc;
    waitIrq(dl); chkEq("R3 staged high not in effect", dl, 4);
    rd(ADR_STAT, d);

    // R4 / R5 / R9: vector walk over every divider setting
    for (int i = 0; i < NVEC; i++) begin
      int p = int'(VEC[i][11:8]);
      int per = int'(VEC[i][7:0]);
      arm(modeWord(p, 1'b0, 1'b0), 32'h0, BUS_W'(per), 1'b1);
      waitIrq(dl);
      chkEq($sformatf("R5 R4 first event p=%0d P=%0d", p, per), dl, (per + 1) * (p + 1));
      rd(ADR_STAT, d); chkEq("R9 status set", d, 1);
      chkEq("R9 irq cleared by read", irqOut, 0);
    end

    // R6: continuous repeats
    arm(modeWord(1, 1'b0, 1'b1), 32'h0, 32'h4, 1'b1);
    for (int n = 1; n <= 3; n++) begin
      waitIrq(dl);
      chkEq($sformatf("R6 event %0d", n), dl, 10 * n);
      rd(ADR_STAT, d);
    end

    // R7: single event then halt at P
    arm(modeWord(0, 1'b0, 1'b0), 32'h0, 32'h3, 1'b1);
    waitIrq(dl); chkEq("R7 event time", dl, 4);
    rd(ADR_STAT, d);
    repeat (40) @(negedge clk);
    chkEq("R7 no second event", irqOut, 0);
    rd(ADR_CNTLO, d); chkEq("R7 count held at P", d, 3);

    // R9: event recorded with interrupt disabled
    arm(modeWord(0, 1'b0, 1'b0), 32'h0, 32'h5, 1'b0);
    repeat (20) @(negedge clk);
    chkEq("R9 irq masked", irqOut, 0);
    rd(ADR_STAT, d); chkEq("R9 pending while masked", d, 1);
    rd(ADR_STAT, d); chkEq("R9 pending cleared", d, 0);

    // R12: restart while running
    arm(modeWord(0, 1'b0, 1'b0), 32'h0, 32'd20, 1'b1);
    repeat (10) @(negedge clk);
    wr(ADR_CTRL, 32'h1);
    startCyc = cyc;
    waitIrq(dl); chkEq("R12 event after restart", dl, 21);
    rd(ADR_STAT, d);

    // R11: software reset clears run state, keeps configuration
    arm(modeWord(0, 1'b0, 1'b1), 32'h0, 32'h2, 1'b1);
    waitIrq(dl);
    wr(ADR_CTRL, 32'h100);
    chkEq("R11 irq dropped", irqOut, 0);
    rd(ADR_CNTLO, d); chkEq("R11 count cleared", d, 0);
    rd(ADR_STAT, d);  chkEq("R11 pending cleared", d, 0);
    rd(ADR_MODE, d);  chkEq("R11 mode kept", d, 1);
    wr(ADR_CTRL, 32'h101);
    repeat (10) @(negedge clk);
    rd(ADR_CNTLO, d); chkEq("R11 start ignored with reset", d, 0);
    chkEq("R11 no event", irqOut, 0);

    // R8: alternate source
    arm(modeWord(1, 1'b1, 1'b0), 32'h0, 32'd100, 1'b1);
    repeat (20) @(negedge clk);
    rd(ADR_CNTLO, d); chkEq("R8 idle alternate source", d, 0);
    for (int j = 0; j < 6; j++) pulseAlt();
    rd(ADR_CNTLO, d); chkEq("R8 six pulses at p=1", d, 3);

    // R10: coherent read across a low-word carry
    arm(modeWord(0, 1'b0, 1'b1), 32'h10, 32'h0, 1'b0);
    @(negedge clk);
    force dut_i.dpI.count = 64'h0000_0000_FFFF_FFF0;
    @(negedge clk);
    release dut_i.dpI.count;
    rd(ADR_CNTLO, d); chkEq("R10 low near carry", (d >= 32'hFFFF_FFE0) ? 1 : 0, 1);
    repeat (40) @(negedge clk);
    rd(ADR_CNTHI, d); chkEq("R10 high from capture", d, 0);
    rd(ADR_CNTLO, d); chkEq("R10 low after carry", (d < 32'h100) ? 1 : 0, 1);
    rd(ADR_CNTHI, d); chkEq("R10 high after new capture", d, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule